// File: doc/BRIEF.md
# Two-Entry-Per-Word Colour Lookup Memory

This block holds a 256-entry colour table for a display controller. Software reaches the table through a simple register-style bus. The table occupies 128 words of the controller's address window, and each 32-bit word carries two 16-bit colour entries. A bus read returns a stored word exactly as it was written. Byte enables let software update either 16-bit entry of a word without touching the other.

A second, independent port serves the pixel pipeline. It takes an 8-bit colour index and, one cycle later, returns a 24-bit RGB value with a valid strobe. Each entry holds three 5-bit channels and one intensity bit. The lookup widens each channel to 8 bits and discards the intensity bit. A channel-order input swaps which stored channel appears in the red and blue lanes of the output.

Top module: `pal_lut`

## Requirements
- R1: Only byte offsets 0x200 through 0x3FF, where bus_addr[11:9] equals 3'b001, select the table, and the word index is bus_addr[8:2]. A write outside that window changes no stored word. A read outside it returns zero.
- R2: A write stores each byte lane whose bus_be bit is set, with bit k covering bits [8k+7:8k]. A read issued with bus_ren returns the raw stored word on bus_rdata in the next cycle.
- R3: bus_rdata is zero in every cycle that does not follow an in-window read.
- R4: Entry index i lives in word i>>1. An even index uses bits [15:0] of that word and an odd index uses bits [31:16].
- R5: Within an entry, bits [4:0] form the first channel, bits [9:5] the green channel and bits [14:10] the third channel. Each channel is widened to 8 bits as {field, 3'b000}. Bit 15 has no effect on the lookup result.
- R6: With px_bgr low, px_rgb[23:16] carries the first channel, px_rgb[15:8] carries green and px_rgb[7:0] carries the third channel. With px_bgr high, the first and third channels trade places.
- R7: px_valid is high in exactly the cycles that follow a cycle with px_req high. px_rgb is zero whenever px_valid is low.
- R8: A lookup or bus read that addresses a word in the same cycle as a write to that word returns the word's contents from before the write.
- R9: After reset, px_valid, px_rgb and bus_rdata are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset within the controller window |
| bus_wen | input | 1 | Write strobe |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after bus_ren |
| px_req | input | 1 | Lookup request |
| px_idx | input | 8 | Colour index to look up |
| px_bgr | input | 1 | Swap the red and blue output lanes |
| px_valid | output | 1 | Lookup result valid |
| px_rgb | output | 24 | Widened colour, red in [23:16], blue in [7:0] |

## Verification
The assertions cover only the strobe timing, out-of-window reads and the zero low bits of each widened channel. They assume nothing about the table contents. They do rely on the inputs being known, 0 or 1, on every clock edge once reset is released, and the stimulus drives every input to a defined value in every cycle. The table is filled completely before any lookup or read is checked, so no result depends on uninitialised storage. Random bus addresses are drawn from a band slightly wider than the window, which exercises decoding on both sides of each edge.

// File: rtl/pal_lut.sv
module pal_lut #(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wen,
  input  logic [DW/8-1:0]  bus_be,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_ren,
  output logic [DW-1:0]    bus_rdata,
  input  logic             px_req,
  input  logic [IDX_W-1:0] px_idx,
  input  logic             px_bgr,
  output logic             px_valid,
  output logic [23:0]      px_rgb
);
  localparam int WORDS = (1 << IDX_W) / 2;
  localparam int WI_W  = IDX_W - 1;
  localparam int HW    = DW / 2;

  logic [DW-1:0] mem [WORDS];

  logic          win;
  logic [WI_W-1:0] widx;
  assign win  = (bus_addr[AW-1:9] == 1);
  assign widx = bus_addr[WI_W+1:2];

  always_ff @(posedge clk) begin
    if (bus_wen && win)
      for (int b = 0; b < DW/8; b++)
        if (bus_be[b]) mem[widx][8*b +: 8] <= bus_wdata[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= (bus_ren && win) ? mem[widx] : '0;
  end

  logic [DW-1:0] pword;
  logic [HW-1:0] entry;
  logic [7:0]    ch_a, ch_g, ch_c;
  assign pword = mem[px_idx[IDX_W-1:1]];
  assign entry = px_idx[0] ? pword[DW-1:HW] : pword[HW-1:0];
  assign ch_a  = {entry[4:0],   3'b000};
  assign ch_g  = {entry[9:5],   3'b000};
  assign ch_c  = {entry[14:10], 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_valid <= 1'b0;
      px_rgb   <= '0;
    end else begin
      px_valid <= px_req;
      if (!px_req)     px_rgb <= '0;
      else if (px_bgr) px_rgb <= {ch_c, ch_g, ch_a};
      else             px_rgb <= {ch_a, ch_g, ch_c};
    end
  end

  assert_valid_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    px_req |=> px_valid);
  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !px_req |=> (!px_valid && px_rgb == 24'd0));
  assert_outside_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && !win) |=> (bus_rdata == '0));
  assert_idle_rdata_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ren |=> (bus_rdata == '0));
  assert_widen_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> (px_rgb[18:16] == 3'd0 && px_rgb[10:8] == 3'd0 && px_rgb[2:0] == 3'd0));
endmodule

// File: tb/pal_lut_test.sv
module pal_lut_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ren = 1'b0;
  logic [31:0] bus_rdata;
  logic        px_req = 1'b0;
  logic [7:0]  px_idx = '0;
  logic        px_bgr = 1'b0;
  logic        px_valid;
  logic [23:0] px_rgb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] model [128];

  pal_lut uut (.*);

  always #10 clk = ~clk;

  function automatic logic [23:0] exp_rgb(input logic [31:0] w, input logic odd, input logic b);
    logic [15:0] e;
    logic [7:0] a, g, c;
    e = odd ? w[31:16] : w[15:0];
    a = {e[4:0], 3'b000};
    g = {e[9:5], 3'b000};
    c = {e[14:10], 3'b000};
    return b ? {c, g, a} : {a, g, c};
  endfunction

  function automatic logic in_win(input logic [11:0] a);
    return a[11:9] == 3'b001;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wen, input logic ren, input logic [11:0] a, input logic [31:0] d,
                     input logic [3:0] be, input logic req, input logic [7:0] idx, input logic b,
                     input string rtag, input string ptag);
    logic [31:0] er;
    logic [23:0] ep;
    er = (ren && in_win(a)) ? model[a[8:2]] : 32'd0;
    ep = req ? exp_rgb(model[idx[7:1]], idx[0], b) : 24'd0;
    bus_wen = wen; bus_ren = ren; bus_addr = a; bus_wdata = d; bus_be = be;
    px_req = req; px_idx = idx; px_bgr = b;
    @(negedge clk);
    check(bus_rdata == er, rtag, bus_rdata, er);
    check(px_valid == req, "R7", {31'd0, px_valid}, {31'd0, req});
    check(px_rgb == ep, ptag, {8'd0, px_rgb}, {8'd0, ep});
    if (wen && in_win(a))
      for (int k = 0; k < 4; k++)
        if (be[k]) model[a[8:2]][8*k +: 8] = d[8*k +: 8];
    bus_wen = 0; bus_ren = 0; px_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(px_valid == 0 && px_rgb == 0 && bus_rdata == 0, "R9",
          {px_valid, 7'd0, px_rgb}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 128; i++) begin
      model[i] = 32'd0;
      cyc(1, 0, 12'h200 + 12'(i*4), $urandom, 4'hF, 0, 8'd0, 0, "R2", "R7");
    end

    // R2: full readback
    for (int i = 0; i < 128; i++)
      cyc(0, 1, 12'h200 + 12'(i*4), 32'd0, 4'h0, 0, 8'd0, 0, "R2", "R7");

    // R1: edges of the window
    cyc(1, 0, 12'h1FC, 32'hDEAD_BEEF, 4'hF, 0, 8'd0, 0, "R1", "R7");
    cyc(1, 0, 12'h400, 32'hCAFE_F00D, 4'hF, 0, 8'd0, 0, "R1", "R7");
    cyc(0, 1, 12'h1FC, 32'd0, 4'h0, 0, 8'd0, 0, "R1", "R7");
    cyc(0, 1, 12'h400, 32'd0, 4'h0, 0, 8'd0, 0, "R1", "R7");
    cyc(0, 1, 12'h200, 32'd0, 4'h0, 0, 8'd0, 0, "R1", "R7");
    cyc(0, 1, 12'h3FC, 32'd0, 4'h0, 0, 8'd0, 0, "R1", "R7");

    // R4/R5/R6: directed channel and half selection with intensity bit set
    cyc(1, 0, 12'h204, 32'hFC00_801F, 4'hF, 0, 8'd0, 0, "R2", "R7");
    cyc(0, 0, 12'h0, 32'd0, 4'h0, 1, 8'd2, 0, "R3", "R4");
    cyc(0, 0, 12'h0, 32'd0, 4'h0, 1, 8'd3, 0, "R3", "R4");
    cyc(0, 0, 12'h0, 32'd0, 4'h0, 1, 8'd2, 1, "R3", "R6");
    cyc(0, 0, 12'h0, 32'd0, 4'h0, 1, 8'd3, 1, "R3", "R6");
    cyc(1, 0, 12'h208, 32'h03E0_83E0, 4'hF, 0, 8'd0, 0, "R2", "R7");
    cyc(0, 0, 12'h0, 32'd0, 4'h0, 1, 8'd4, 0, "R3", "R5");
    cyc(0, 0, 12'h0, 32'd0, 4'h0, 1, 8'd5, 1, "R3", "R5");

    // R2: half-word writes via byte enables
    cyc(1, 0, 12'h20C, 32'h1234_5678, 4'h3, 0, 8'd0, 0, "R2", "R7");
    cyc(1, 0, 12'h20C, 32'h9ABC_DEF0, 4'hC, 0, 8'd0, 0, "R2", "R7");
    cyc(0, 1, 12'h20C, 32'd0, 4'h0, 1, 8'd6, 0, "R2", "R4");

    // R8: same-cycle write and access to the same word return old contents
    cyc(1, 1, 12'h210, 32'h7FFF_7FFF, 4'hF, 1, 8'd8, 0, "R8", "R8");
    cyc(0, 1, 12'h210, 32'd0, 4'h0, 1, 8'd9, 1, "R8", "R8");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [11:0] a;
      a = 12'($urandom_range(12'h1C0, 12'h43F)) & 12'hFFC;
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom, 4'($urandom),
          1'($urandom_range(0, 1)), 8'($urandom), 1'($urandom_range(0, 1)), "R2", "R5");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule